// File: doc/BRIEF.md
# SPI Flash Status Register Writer

This block is the slave-side status register logic of a serial flash device. A host drives a mode-0 SPI bus (serial clock, active-low chip-select, data in) into the block. The block oversamples the bus in its own system clock domain. It decodes three instructions: write-enable, status write and status read. It keeps an 8-bit status register and answers status reads on the data-out line.

A status write is carried out only if several conditions all hold. The write-enable latch must be set. The hardware guard must allow the write, which depends on the guard bit and the active-low write-protect pin. The frame must end exactly on the boundary after the data byte. An accepted write updates only the non-volatile bits. It then starts a self-timed busy period. When that period ends, busy clears and the write-enable latch clears with it. The host polls busy with status reads, which stay available while the device is busy.

Status layout: bit 7 is the guard bit, bits 4..2 form the protect field, bits 6..5 always read zero, bit 1 is the write-enable latch and bit 0 is busy. The register value is also exposed as a port for checking.

Top module: `spi_status_writer`

## Requirements
- R1: Opcode 8'h06 in a frame of exactly 8 bits, ended by chip-select rising, sets the write-enable latch (status bit 1). Frames of 7 or 12 bits with that opcode leave the status unchanged.
- R2: Opcode 8'h01 followed by one data byte is accepted only if status bit 1 is 1 when chip-select rises. Otherwise the status stays unchanged and busy stays 0.
- R3: An accepted write copies data bits 7, 4, 3 and 2 into the same status bits. Status bits 6 and 5 always read 0, and bits 1 and 0 are never taken from the data.
- R4: A status write frame is dropped unless chip-select rises after exactly 16 bits. A dropped frame changes no status bit, leaves the latch set and starts no busy period.
- R5: An accepted write sets busy (bit 0) for exactly TW_CYCLES system clock cycles. When busy returns to 0, bit 1 reads 0.
- R6: Opcode 8'h05 returns the status byte MSB first on MISO, starting with the bit after the opcode. MISO changes on falling SCLK and is valid at the next rising SCLK. The byte repeats while chip-select stays low, and the read works while busy is 1.
- R7: With bit 7 set and the write-protect pin low, a status write is rejected: status is unchanged and the latch stays 1. With the pin high, or with bit 7 clear, the write is accepted.
- R8: While busy is 1, every instruction other than the status read is ignored, including a complete status write.
- R9: After reset the status reads 8'h00 and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock, mode 0 |
| cs_ni | input | 1 | SPI chip-select, active low |
| mosi_i | input | 1 | SPI data from host |
| wp_ni | input | 1 | Write-protect pin, active low |
| miso_o | output | 1 | SPI data to host |
| status_o | output | 8 | Current status register value |

## Verification
The bench sends write frames of every length from 8 to 24 bits around the 16-bit boundary. A design that counts bits off by one, or that accepts any frame of at least 16 bits, would commit an aborted frame and start busy. It tries all four combinations of the guard bit and the protect pin, where a wrong lock-out polarity or a check taken from the pin alone would block or pass the wrong case. It sweeps data patterns that cover every value of the writable bits and sets the read-only bits to 1, so a wrong mask leaks into bits 6, 5, 1 or 0. It also measures the busy length, reads status during busy and sends a write while busy. These catch an off-by-one timer, a read path gated by busy, and a second write that slips in before the timer expires.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam int BYTE_BITS = 8;
  localparam int IDX_W     = $clog2(BYTE_BITS);
  localparam int CNT_W     = 2;

  localparam logic [7:0] OP_WR_ENABLE = 8'h06;
  localparam logic [7:0] OP_SR_WRITE  = 8'h01;
  localparam logic [7:0] OP_SR_READ   = 8'h05;

  localparam int BIT_BUSY  = 0;
  localparam int BIT_LATCH = 1;
  localparam int BIT_GUARD = 7;
  localparam logic [7:0] NV_MASK = 8'b1001_1100;

  typedef enum logic [1:0] {CMD_NONE, CMD_WREN, CMD_WRSR} cmd_e;
endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain <= {STAGES{RST_VAL[b]}};
      end else begin
        chain[0] <= d_i[b];
        for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_sr_frontend.sv
module spi_sr_frontend
  import spi_sr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_s_i,
  input  logic                 cs_n_s_i,
  input  logic                 mosi_s_i,
  output logic                 rx_valid_o,
  output logic [BYTE_BITS-1:0] rx_byte_o,
  output logic [CNT_W-1:0]     rx_idx_o,
  output logic                 frame_end_o,
  output logic [CNT_W-1:0]     frame_bytes_o,
  output logic                 frame_aligned_o,
  output logic                 sclk_fall_o,
  output logic [IDX_W-1:0]     bit_idx_o,
  output logic                 active_o
);
  logic                 sclk_d, cs_n_d;
  logic [BYTE_BITS-2:0] shreg;
  logic [IDX_W-1:0]     bit_idx;
  logic [CNT_W-1:0]     byte_cnt;
  logic                 cs_start, sclk_rise;

  assign active_o    = ~cs_n_s_i;
  assign cs_start    = ~cs_n_s_i & cs_n_d;
  assign frame_end_o = cs_n_s_i & ~cs_n_d;
  assign sclk_rise   = active_o & sclk_s_i & ~sclk_d;
  assign sclk_fall_o = active_o & ~sclk_s_i & sclk_d;

  assign frame_bytes_o   = byte_cnt;
  assign frame_aligned_o = (bit_idx == '0);
  assign bit_idx_o       = bit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_n_d <= 1'b1;
    end else begin
      sclk_d <= sclk_s_i;
      cs_n_d <= cs_n_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg      <= '0;
      bit_idx    <= '0;
      byte_cnt   <= '0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
      rx_idx_o   <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (cs_start) begin
        bit_idx  <= '0;
        byte_cnt <= '0;
      end else if (sclk_rise) begin
        shreg   <= {shreg[BYTE_BITS-3:0], mosi_s_i};
        bit_idx <= bit_idx + 1'b1;
        if (bit_idx == IDX_W'(BYTE_BITS - 1)) begin
          rx_valid_o <= 1'b1;
          rx_byte_o  <= {shreg, mosi_s_i};
          rx_idx_o   <= byte_cnt;
          if (byte_cnt != '1) byte_cnt <= byte_cnt + 1'b1;  // saturate: long frames stay invalid
        end
      end
    end
  end
endmodule

// File: rtl/spi_sr_ctrl.sv
module spi_sr_ctrl
  import spi_sr_pkg::*;
#(
  parameter int         TW_CYCLES = 64,
  parameter logic [7:0] NV_RESET  = 8'h00
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_valid_i,
  input  logic [BYTE_BITS-1:0] rx_byte_i,
  input  logic [CNT_W-1:0]     rx_idx_i,
  input  logic                 frame_end_i,
  input  logic [CNT_W-1:0]     frame_bytes_i,
  input  logic                 frame_aligned_i,
  input  logic                 wp_n_i,
  output logic [7:0]           status_o,
  output logic                 read_mode_o
);
  localparam int TMR_W = $clog2(TW_CYCLES + 1);

  logic [7:0]       opcode_q, data_q, nv_q;
  logic             latch_q, busy_q;
  logic [TMR_W-1:0] tmr_q;
  cmd_e             cmd;
  logic             guard_ok, accept_wr;

  always_comb begin
    cmd = CMD_NONE;
    if (frame_end_i && frame_aligned_i) begin
      if (opcode_q == OP_WR_ENABLE && frame_bytes_i == CNT_W'(1))     cmd = CMD_WREN;
      else if (opcode_q == OP_SR_WRITE && frame_bytes_i == CNT_W'(2)) cmd = CMD_WRSR;
    end
  end

  assign guard_ok  = ~(nv_q[BIT_GUARD] & ~wp_n_i);
  assign accept_wr = (cmd == CMD_WRSR) & latch_q & guard_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opcode_q <= '0;
      data_q   <= '0;
    end else if (rx_valid_i) begin
      if (rx_idx_i == '0)            opcode_q <= rx_byte_i;
      else if (rx_idx_i == CNT_W'(1)) data_q  <= rx_byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      read_mode_o <= 1'b0;
    end else if (frame_end_i) begin
      read_mode_o <= 1'b0;
    end else if (rx_valid_i && rx_idx_i == '0) begin
      read_mode_o <= (rx_byte_i == OP_SR_READ);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_q    <= NV_RESET & NV_MASK;
      latch_q <= 1'b0;
      busy_q  <= 1'b0;
      tmr_q   <= '0;
    end else if (busy_q) begin
      if (tmr_q == '0) begin
        busy_q  <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        tmr_q <= tmr_q - 1'b1;
      end
    end else begin
      if (cmd == CMD_WREN) latch_q <= 1'b1;
      if (accept_wr) begin
        nv_q   <= data_q & NV_MASK;
        busy_q <= 1'b1;
        tmr_q  <= TMR_W'(TW_CYCLES - 1);
      end
    end
  end

  always_comb begin
    status_o            = nv_q & NV_MASK;
    status_o[BIT_LATCH] = latch_q;
    status_o[BIT_BUSY]  = busy_q;
  end
endmodule

// File: rtl/spi_sr_tx.sv
module spi_sr_tx
  import spi_sr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             read_mode_i,
  input  logic             sclk_fall_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic [7:0]       status_i,
  output logic             miso_o
);
  logic [7:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      miso_o <= 1'b0;
    end else if (!active_i) begin
      miso_o <= 1'b0;
    end else if (read_mode_i && sclk_fall_i) begin
      if (bit_idx_i == '0) begin
        snap_q <= status_i;  // fresh copy at every byte start so busy is live
        miso_o <= status_i[7];
      end else begin
        miso_o <= snap_q[IDX_W'(7) - bit_idx_i];
      end
    end
  end
endmodule

// File: rtl/spi_status_writer.sv
module spi_status_writer
  import spi_sr_pkg::*;
#(
  parameter int         TW_CYCLES   = 64,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] NV_RESET    = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  input  logic       wp_ni,
  output logic       miso_o,
  output logic [7:0] status_o
);
  logic [3:0]           raw, synced;
  logic                 sclk_s, cs_n_s, mosi_s, wp_n_s;
  logic                 rx_valid, frame_end, frame_aligned, sclk_fall, active, read_mode;
  logic [BYTE_BITS-1:0] rx_byte;
  logic [CNT_W-1:0]     rx_idx, frame_bytes;
  logic [IDX_W-1:0]     bit_idx;

  assign raw    = {wp_ni, mosi_i, cs_ni, sclk_i};
  assign sclk_s = synced[0];
  assign cs_n_s = synced[1];
  assign mosi_s = synced[2];
  assign wp_n_s = synced[3];

  spi_sr_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(synced)
  );

  spi_sr_frontend u_front (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sclk_s_i(sclk_s), .cs_n_s_i(cs_n_s), .mosi_s_i(mosi_s),
    .rx_valid_o(rx_valid), .rx_byte_o(rx_byte), .rx_idx_o(rx_idx),
    .frame_end_o(frame_end), .frame_bytes_o(frame_bytes),
    .frame_aligned_o(frame_aligned), .sclk_fall_o(sclk_fall),
    .bit_idx_o(bit_idx), .active_o(active)
  );

  spi_sr_ctrl #(.TW_CYCLES(TW_CYCLES), .NV_RESET(NV_RESET)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .rx_idx_i(rx_idx),
    .frame_end_i(frame_end), .frame_bytes_i(frame_bytes),
    .frame_aligned_i(frame_aligned), .wp_n_i(wp_n_s),
    .status_o(status_o), .read_mode_o(read_mode)
  );

  spi_sr_tx u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .active_i(active), .read_mode_i(read_mode), .sclk_fall_i(sclk_fall),
    .bit_idx_i(bit_idx), .status_i(status_o), .miso_o(miso_o)
  );
endmodule

// File: rtl/spi_status_writer_chk.sv
module spi_status_writer_chk #(
  parameter int TW_CYCLES = 64
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] status_i,
  input logic       wp_n_s_i
);
  int busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_run <= 0;
    else if (status_i[0]) busy_run <= busy_run + 1;
    else                  busy_run <= 0;
  end

  assert_latch_needed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_i[0]) |-> $past(status_i[1]));

  assert_ro_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[6:5] == 2'b00);

  assert_nv_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(status_i[0]) |-> $stable({status_i[7], status_i[4:2]}));

  assert_busy_clears_latch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_i[0]) |-> !status_i[1]);

  assert_busy_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_i[0]) |-> busy_run == TW_CYCLES);

  assert_guard_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_i[0]) |-> !($past(status_i[7]) && !$past(wp_n_s_i)));

  assert_no_latch_in_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_i[1]) |-> !$past(status_i[0]));
endmodule

bind spi_status_writer spi_status_writer_chk #(.TW_CYCLES(TW_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .status_i(status_o), .wp_n_s_i(wp_n_s)
);

// File: tb/spi_status_writer_test.sv
module spi_status_writer_test;
  localparam int TW = 400;
  localparam int HP = 8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic       miso;
  logic [7:0] status;
  int         checks = 0, fails = 0;
  int         run = 0, last_run = 0;

  always #5 clk = ~clk;

  spi_status_writer #(.TW_CYCLES(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n),
    .mosi_i(mosi), .wp_ni(wp_n), .miso_o(miso), .status_o(status)
  );

  always @(negedge clk) begin
    if (status[0]) run++;
    else begin
      if (run != 0) last_run = run;
      run = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] data, input int nbits, output logic [31:0] rd);
    rd = '0;
    cs_n = 1'b0;
    wait_cyc(HP);
    for (int i = 0; i < nbits; i++) begin
      mosi = data[31-i];
      wait_cyc(HP);
      rd = {rd[30:0], miso};
      sclk = 1'b1;
      wait_cyc(HP);
      sclk = 1'b0;
    end
    wait_cyc(HP);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_cyc(16);
  endtask

  task automatic wren();
    logic [31:0] rd;
    xfer({8'h06, 24'h0}, 8, rd);
  endtask

  task automatic wrsr(input logic [7:0] d);
    logic [31:0] rd;
    xfer({8'h01, d, 16'h0}, 16, rd);
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [31:0] rd;
    xfer({8'h05, 24'h0}, 16, rd);
    v = rd[7:0];
  endtask

  task automatic wait_idle();
    int g = 0;
    while (status[0] && g < 5000) begin
      wait_cyc(1);
      g++;
    end
    wait_cyc(2);
  endtask

  function automatic logic [7:0] expv(input logic [7:0] nv, input bit wl, input bit bz);
    return (nv & 8'h9C) | {6'b0, wl, bz};
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0]  v, d, nv;
    logic [31:0] rd;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(4);
    check("R9 reset status", status, 8'h00);
    check("R9 reset miso", miso, 1'b0);

    rdsr(v);
    check("R6 read idle", v, 8'h00);

    xfer({8'h06, 24'h0}, 7, rd);
    check("R1 short enable frame", status, 8'h00);
    xfer({8'h06, 24'hFFFFFF}, 12, rd);
    check("R1 long enable frame", status, 8'h00);
    wren();
    check("R1 enable sets latch", status, 8'h02);
    rdsr(v);
    check("R6 read latch", v, 8'h02);

    nv = 8'h00;
    for (int i = 0; i < 64; i++) begin
      d = 8'(i * 37 + 5);
      wren();
      wrsr(d);
      check("R3 writable bits", status, expv(d, 1, 1));
      rdsr(v);
      check("R6 read during busy", v, expv(d, 1, 1));
      wait_idle();
      check("R5 after busy", status, expv(d, 0, 0));
      check("R5 busy length", last_run, TW);
      nv = d;
    end

    wrsr(8'h9C);
    check("R2 write without latch", status, expv(nv, 0, 0));
    wait_cyc(40);
    check("R2 no busy without latch", status, expv(nv, 0, 0));
    wrsr(8'h00);
    wait_idle();

    nv = 8'h00;
    wren();
    for (int n = 8; n <= 24; n++) begin
      if (n != 16) begin
        xfer({8'h01, 8'h9C, 16'hFFFF}, n, rd);
        check("R4 aborted frame", status, expv(nv, 1, 0));
      end
    end
    wrsr(8'h9C);
    check("R4 exact frame accepted", status, expv(8'h9C, 1, 1));
    wait_idle();
    nv = 8'h9C;

    wp_n = 1'b0;
    wren();
    wrsr(8'h0C);
    check("R7 guard locks write", status, expv(nv, 1, 0));
    wait_cyc(40);
    check("R7 no busy when locked", status, expv(nv, 1, 0));
    wp_n = 1'b1;
    wrsr(8'h0C);
    check("R7 pin high allows", status, expv(8'h0C, 1, 1));
    wait_idle();
    wp_n = 1'b0;
    wren();
    wrsr(8'h14);
    check("R7 guard clear ignores pin", status, expv(8'h14, 1, 1));
    wait_idle();
    check("R7 final", status, expv(8'h14, 0, 0));
    wp_n = 1'b1;

    wren();
    wrsr(8'h08);
    check("R8 first write busy", status, expv(8'h08, 1, 1));
    wrsr(8'h90);
    check("R8 write ignored while busy", status, expv(8'h08, 1, 1));
    wait_idle();
    check("R8 after busy", status, expv(8'h08, 0, 0));

    xfer({8'h05, 24'h0}, 32, rd);
    check("R6 repeat byte 1", rd[15:8], 8'h08);
    check("R6 repeat byte 2", rd[7:0], 8'h08);
    wren();
    xfer({8'h05, 24'h0}, 24, rd);
    check("R6 repeat with latch 1", rd[15:8], 8'h0A);
    check("R6 repeat with latch 2", rd[7:0], 8'h0A);

    finish_run();
  end
endmodule